// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block is the hazard control for an in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. Every instruction writes its result in stage five; one that does no memory work passes through stage four unchanged. The register file returns a value written in the same cycle as the read. Because of this, only two results can still be missing from the register file when an operand is read: the one in the execute/memory pipeline register and the one in the memory/write-back pipeline register.

The block is purely combinational. For each of the two source registers of the instruction in execute, it picks one of three inputs for the ALU operand: the register file, the execute/memory result or the write-back result. It also watches the instruction in decode. A register that decode reads may be the target of a load that is now in execute. That value only exists after the memory stage, so the block holds the program counter and the fetch/decode register for one cycle. In that same cycle it turns the entry going into the decode/execute register into a bubble. The bubble clears the register-write, memory-write and branch enables.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the execute-stage source matches the destination of the execute/memory register, that register's write enable is 1 and the destination is not zero, the operand select is 2'b10.
- R2: When only the memory/write-back destination qualifies (match, write enable 1, destination not zero), the operand select is 2'b01.
- R3: When both later stages qualify for the same source, the execute/memory result wins and the select is 2'b10.
- R4: Register zero never causes forwarding and never causes a stall, whatever the enables are.
- R5: A destination whose stage has its write enable at 0 is never matched. A qualifying older stage is still used in that case.
- R6: When no later stage qualifies, the select is 2'b00 (register file). This covers a producer three instructions ahead, which the register file bypasses on its own.
- R7: When the execute-stage instruction is a load (memory-read 1, write enable 1) and its nonzero destination equals either decode source, the stall output and the bubble output are both 1.
- R8: The stall and bubble outputs are always equal. They stay 0 when the execute-stage producer is not a load or its destination matches neither decode source.
- R9: Each operand select depends only on its own source register, so the two operands may take different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | AW | First source register of the instruction in execute |
| ex_src_b | input | AW | Second source register of the instruction in execute |
| id_src_a | input | AW | First source register of the instruction in decode |
| id_src_b | input | AW | Second source register of the instruction in decode |
| ex_dst | input | AW | Destination of the instruction in execute |
| ex_wr_en | input | 1 | Register-write enable of the instruction in execute |
| ex_is_load | input | 1 | Memory-read flag of the instruction in execute |
| mem_dst | input | AW | Destination held in the execute/memory register |
| mem_wr_en | input | 1 | Register-write enable held in the execute/memory register |
| wb_dst | input | AW | Destination held in the memory/write-back register |
| wb_wr_en | input | 1 | Register-write enable held in the memory/write-back register |
| opnd_a_sel | output | 2 | Source for ALU operand A: 00 register file, 01 write-back, 10 execute/memory |
| opnd_b_sel | output | 2 | Source for ALU operand B, same encoding |
| hold_front | output | 1 | Freezes the program counter and the fetch/decode register |
| bubble_ex | output | 1 | Clears the control enables going into the decode/execute register |

## Verification
The bench drives both later stages with the same destination. A design with the priority reversed would feed the ALU the older write-back value. It drives destination zero with every enable set, where a missing zero guard would forward a dead value or stall for no reason. It drives a matching destination with its write enable cleared, where an ungated compare would forward a result that never gets written. The load cases use each decode source in turn, and also an ALU producer to the same register. These catch an interlock that checks only one source, or one that stalls on non-load producers and wastes a cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } opnd_src_e;

    typedef struct packed {
        opnd_src_e src_a;
        opnd_src_e src_b;
        logic      hold;
        logic      bubble;
    } hzd_ctl_t;

endpackage

// File: rtl/hzd_opnd_sel.sv
module hzd_opnd_sel
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_en,
    output opnd_src_e     sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wr_en && (mem_dst != '0) && (mem_dst == src);
        wb_hit  = wb_wr_en  && (wb_dst  != '0) && (wb_dst  == src);
        // the younger result is checked first
        if (mem_hit)
            sel = SRC_MEM;
        else if (wb_hit)
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_load_lock.sv
module hzd_load_lock #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic [AW-1:0]           ex_dst,
    input  logic                    ex_wr_en,
    input  logic                    ex_is_load,
    output logic                    lock
);
    logic [NSRC-1:0] hit;
    logic            load_live;

    assign load_live = ex_is_load && ex_wr_en && (ex_dst != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = load_live && (id_src[i] == ex_dst);
    end

    assign lock = |hit;
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hzd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr_en,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr_en,
    output logic [1:0]    opnd_a_sel,
    output logic [1:0]    opnd_b_sel,
    output logic          hold_front,
    output logic          bubble_ex
);
    localparam int NOPND = 2;

    logic [NOPND-1:0][AW-1:0] ex_src;
    logic [NOPND-1:0][AW-1:0] id_src;
    opnd_src_e                sel    [NOPND];
    logic                     lock;
    hzd_ctl_t                 ctl_d;

    assign ex_src = {ex_src_b, ex_src_a};
    assign id_src = {id_src_b, id_src_a};

    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
        hzd_opnd_sel #(.AW(AW)) u_sel (
            .src       (ex_src[k]),
            .mem_dst   (mem_dst),
            .mem_wr_en (mem_wr_en),
            .wb_dst    (wb_dst),
            .wb_wr_en  (wb_wr_en),
            .sel       (sel[k])
        );
    end

    hzd_load_lock #(.AW(AW), .NSRC(NOPND)) u_lock (
        .id_src     (id_src),
        .ex_dst     (ex_dst),
        .ex_wr_en   (ex_wr_en),
        .ex_is_load (ex_is_load),
        .lock       (lock)
    );

    always_comb begin
        ctl_d        = '0;
        ctl_d.src_a  = sel[0];
        ctl_d.src_b  = sel[1];
        ctl_d.hold   = lock;
        ctl_d.bubble = lock;
    end

    assign opnd_a_sel = ctl_d.src_a;
    assign opnd_b_sel = ctl_d.src_b;
    assign hold_front = ctl_d.hold;
    assign bubble_ex  = ctl_d.bubble;
endmodule

// File: rtl/hzd_chk.sv
module hzd_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ex_src_a,
    input logic [AW-1:0] ex_src_b,
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic [AW-1:0] ex_dst,
    input logic          ex_wr_en,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_dst,
    input logic          mem_wr_en,
    input logic [AW-1:0] wb_dst,
    input logic          wb_wr_en,
    input logic [1:0]    opnd_a_sel,
    input logic [1:0]    opnd_b_sel,
    input logic          hold_front,
    input logic          bubble_ex
);
    logic known;

    always_comb begin
        known = !$isunknown({ex_src_a, ex_src_b, id_src_a, id_src_b, ex_dst,
                             ex_wr_en, ex_is_load, mem_dst, mem_wr_en,
                             wb_dst, wb_wr_en});
        if (known) begin
            // R1
            if (opnd_a_sel == 2'b10) begin
                mem_src_a_chk: assert (mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a);
            end
            // R3
            if (mem_wr_en && mem_dst != '0 && mem_dst == ex_src_b) begin
                mem_first_b_chk: assert (opnd_b_sel == 2'b10);
            end
            // R2
            if (opnd_b_sel == 2'b01) begin
                wb_src_b_chk: assert (wb_wr_en && wb_dst != '0 && wb_dst == ex_src_b
                                      && !(mem_wr_en && mem_dst == ex_src_b));
            end
            // R4
            if (ex_src_a == '0) begin
                zero_reg_a_chk: assert (opnd_a_sel == 2'b00);
            end
            // R8
            stall_pair_chk: assert (hold_front == bubble_ex);
            // R7
            if (hold_front) begin
                load_only_chk: assert (ex_is_load && ex_wr_en && ex_dst != '0
                                       && (ex_dst == id_src_a || ex_dst == id_src_b));
            end
        end
    end
endmodule

bind pipe_hazard_ctl hzd_chk #(.AW(AW)) u_hzd_chk (
    .ex_src_a   (ex_src_a),
    .ex_src_b   (ex_src_b),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .ex_dst     (ex_dst),
    .ex_wr_en   (ex_wr_en),
    .ex_is_load (ex_is_load),
    .mem_dst    (mem_dst),
    .mem_wr_en  (mem_wr_en),
    .wb_dst     (wb_dst),
    .wb_wr_en   (wb_wr_en),
    .opnd_a_sel (opnd_a_sel),
    .opnd_b_sel (opnd_b_sel),
    .hold_front (hold_front),
    .bubble_ex  (bubble_ex)
);

// File: tb/pipe_hazard_ctl_test.sv
module pipe_hazard_ctl_test;
    localparam int AW = 5;

    typedef struct packed {
        logic [AW-1:0] exa, exb, ida, idb, exd;
        logic          exw, exl;
        logic [AW-1:0] memd;
        logic          memw;
        logic [AW-1:0] wbd;
        logic          wbw;
        logic [1:0]    ea, eb;
        logic          es;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R6 idle: everything zero
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 8'd6},
        // R1 operand A from execute/memory
        '{5'd3, 5'd4, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 8'd1},
        // R2 operand B from write-back
        '{5'd3, 5'd4, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, 2'b00, 2'b01, 1'b0, 8'd2},
        // R3 both stages hold r5
        '{5'd5, 5'd5, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 5'd5, 1'b1, 2'b10, 2'b10, 1'b0, 8'd3},
        // R9 A from memory stage, B from write-back
        '{5'd6, 5'd7, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 5'd7, 1'b1, 2'b10, 2'b01, 1'b0, 8'd9},
        // R4 register zero everywhere with every enable set
        '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 8'd4},
        // R5 both matches disabled
        '{5'd3, 5'd3, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd3, 1'b0, 5'd3, 1'b0, 2'b00, 2'b00, 1'b0, 8'd5},
        // R5 younger disabled, older used
        '{5'd3, 5'd9, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd3, 1'b0, 5'd3, 1'b1, 2'b01, 2'b00, 1'b0, 8'd5},
        // R7 load feeds decode source A
        '{5'd0, 5'd0, 5'd8, 5'd1, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 8'd7},
        // R7 load feeds decode source B
        '{5'd0, 5'd0, 5'd2, 5'd8, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 8'd7},
        // R8 ALU producer in execute: no stall
        '{5'd0, 5'd0, 5'd8, 5'd8, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 8'd8},
        // R8 load to a register decode does not read
        '{5'd0, 5'd0, 5'd8, 5'd10, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 8'd8},
        // R6 no stage holds the sources
        '{5'd11, 5'd12, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd13, 1'b1, 5'd14, 1'b1, 2'b00, 2'b00, 1'b0, 8'd6}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
    logic          ex_wr_en, ex_is_load, mem_wr_en, wb_wr_en;
    logic [1:0]    opnd_a_sel, opnd_b_sel;
    logic          hold_front, bubble_ex;

    int n_chk  = 0;
    int n_fail = 0;

    pipe_hazard_ctl #(.AW(AW)) uut (
        .ex_src_a   (ex_src_a),
        .ex_src_b   (ex_src_b),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .ex_dst     (ex_dst),
        .ex_wr_en   (ex_wr_en),
        .ex_is_load (ex_is_load),
        .mem_dst    (mem_dst),
        .mem_wr_en  (mem_wr_en),
        .wb_dst     (wb_dst),
        .wb_wr_en   (wb_wr_en),
        .opnd_a_sel (opnd_a_sel),
        .opnd_b_sel (opnd_b_sel),
        .hold_front (hold_front),
        .bubble_ex  (bubble_ex)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        ex_src_a = v.exa; ex_src_b = v.exb; id_src_a = v.ida; id_src_b = v.idb;
        ex_dst = v.exd; ex_wr_en = v.exw; ex_is_load = v.exl;
        mem_dst = v.memd; mem_wr_en = v.memw; wb_dst = v.wbd; wb_wr_en = v.wbw;
        #1;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        string r;
        // R6 idle state: all inputs zero gives no forwarding and no stall
        v = VEC[0];
        apply(v);
        check("R6", "idle A", int'(opnd_a_sel), 0);
        check("R6", "idle B", int'(opnd_b_sel), 0);
        check("R8", "idle stall", int'(hold_front), 0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            apply(v);
            r = $sformatf("R%0d", v.req);
            check(r, $sformatf("vec %0d sel A", i), int'(opnd_a_sel), int'(v.ea));
            check(r, $sformatf("vec %0d sel B", i), int'(opnd_b_sel), int'(v.eb));
            check(r, $sformatf("vec %0d stall", i), int'(hold_front), int'(v.es));
            check("R8", $sformatf("vec %0d bubble", i), int'(bubble_ex), int'(v.es));
        end

        // R1 and R4: sweep every register through the execute/memory stage
        for (int k = 0; k < (1 << AW); k++) begin
            v = '0;
            v.exa = AW'(k); v.exb = AW'(k); v.memd = AW'(k); v.memw = 1'b1;
            apply(v);
            check(k == 0 ? "R4" : "R1", $sformatf("sweep r%0d A", k), int'(opnd_a_sel), k == 0 ? 0 : 2);
            check(k == 0 ? "R4" : "R1", $sformatf("sweep r%0d B", k), int'(opnd_b_sel), k == 0 ? 0 : 2);
        end

        // R7 sweep load destinations against decode source A
        for (int k = 0; k < (1 << AW); k++) begin
            v = '0;
            v.ida = AW'(k); v.exd = AW'(k); v.exw = 1'b1; v.exl = 1'b1;
            apply(v);
            check(k == 0 ? "R4" : "R7", $sformatf("load r%0d stall", k), int'(hold_front), k == 0 ? 0 : 1);
            check("R8", $sformatf("load r%0d bubble", k), int'(bubble_ex), k == 0 ? 0 : 1);
        end

        // R7 load with write enable cleared does not stall
        v = '0;
        v.ida = 5'd4; v.exd = 5'd4; v.exl = 1'b1;
        apply(v);
        check("R7", "load no wr_en stall", int'(hold_front), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule